// File: doc/BRIEF.md
# JTAG TAP Path Sequencer

This block walks a JTAG test access port between the few positions a scan master rests in. It tracks the TAP position. Before any shift the TAP rests in Run-Test/Idle, Pause-IR or Pause-DR. During a payload shift it sits in Shift-IR or Shift-DR. For each accepted request the block emits the exact TMS bit train that takes the TAP where it was asked to go, with TDI held low. The train can be preceded by a reset burst, and a MOVE can be followed by a number of extra Run-Test/Idle clocks. A single-cycle `tick` input paces the bits. Each bit uses two ticks: TCK stays low for one tick interval and then high for one.

A request has four parts: an operation, a target, a reset flag and an extra-idle count. The block takes it over a valid/ready handshake. It answers with a one-cycle `done` pulse after the last TCK falling edge. Payload shifting belongs to the neighbouring shifter. That shifter clocks the final payload bit with TMS high, which leaves the TAP in Exit1, and then issues an EXIT request. If the tracked position has no path for the requested operation, or the target code is illegal, the request produces no TCK edge at all. The block then pulses `err` together with `done`.

Internally a controller FSM has five states. S_IDLE accepts requests. S_BURST emits the reset clocks. S_PATH emits the path from a small ROM. S_EXTRA emits the extra idle clocks. S_DONE pulses done and commits the new position. Its transitions are ACCEPT (S_IDLE to S_BURST, S_PATH or S_DONE), BURST_END (to S_PATH), PATH_END (to S_EXTRA or S_DONE), EXTRA_END (to S_DONE) and COMMIT (S_DONE to S_IDLE). A bit pacer with phases PH_FREE, PH_LOW and PH_HIGH turns each bit into one TCK period. Its transitions are GO (free to low, TMS loaded), RISE (low to high on tick) and FALL (high to free on tick).

Top module: `tap_path_seq`

## Requirements
- R1: After reset, and whenever `rst_n` is low, tck=0, tms=0, done=0, err=0, req_ready=1 and tap_pos=0 (Idle). The position codes are 0 Idle, 1 Pause-IR, 2 Pause-DR, 3 Shift-IR and 4 Shift-DR.
- R2: For a MOVE request (op=0), the target codes are 0 Idle, 1 Pause-IR and 2 Pause-DR. From Idle, the TMS values at successive TCK rising edges are 0 for target Idle, 1,1,0,1,0 for target Pause-IR and 1,0,1,0 for target Pause-DR. tap_pos then equals the target.
- R3: For a MOVE from Pause-IR or Pause-DR, the TMS values are 1,1,0 for target Idle, 1,1,1,1,0,1,0 for target Pause-IR and 1,1,1,0,1,0 for target Pause-DR.
- R4: When req_reset=1 on a MOVE or enter-shift request, 10 clocks with TMS=1 come first, and the path is then taken as if starting from Idle. On an EXIT request (op=3), req_reset has no effect.
- R5: A MOVE ends with req_idle_clks extra clocks at TMS=0, up to the full field range. On enter-shift requests req_idle_clks is ignored.
- R6: Enter Shift-IR (op=1) emits 1,1,0,0 and enter Shift-DR (op=2) emits 1,0,0. From a Pause position, 1,1 comes before either. tap_pos becomes 3 or 4.
- R7: EXIT is valid only from Shift-IR or Shift-DR. It emits 0, followed by 1,1,0 when the target is Idle. With a Pause target (1 or 2) the TAP ends in the Pause of the register that was being shifted.
- R8: A request with no path from the tracked position, or with target 3 on a MOVE or EXIT, emits no TCK edge and no reset burst. It pulses err together with done and leaves tap_pos unchanged.
- R9: TCK rises only on a cycle after tick was high. TMS changes only while TCK is low. TDI is 0 at every rising TCK edge.
- R10: req_ready is high only between operations. done is high for exactly one cycle. tap_pos changes only in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pacing pulse; two ticks per TCK period |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 0 MOVE, 1 enter Shift-IR, 2 enter Shift-DR, 3 EXIT from shift |
| req_target | input | 2 | 0 Idle, 1 Pause-IR, 2 Pause-DR, 3 illegal |
| req_reset | input | 1 | Prepend the TMS-high reset burst |
| req_idle_clks | input | IDLE_W | Extra Idle clocks after a MOVE |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data in, held at 0 |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request had no legal path (valid with done) |
| tap_pos | output | 3 | Tracked TAP position |

## Verification
If the tracked position is wrong, the next request starts on the wrong row of the path table. The very first TMS bits of the next train then differ from the expected ones, or a legal request comes back with err. So the error shows within one request, and the bench compares every TMS bit at every TCK rising edge. A counter or segment fault in the controller shows as a train that is too long or too short. A pacer phase fault shows as TMS moving while TCK is high, or TCK rising without a tick, and the checker flags either in the cycle it happens. A wrong commit shows as tap_pos changing outside the cycle after done.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;

    typedef enum logic [1:0] {
        OP_MOVE     = 2'd0,
        OP_SHIFT_IR = 2'd1,
        OP_SHIFT_DR = 2'd2,
        OP_EXIT     = 2'd3
    } tps_op_e;

    typedef enum logic [1:0] {
        TGT_IDLE     = 2'd0,
        TGT_PAUSE_IR = 2'd1,
        TGT_PAUSE_DR = 2'd2,
        TGT_BAD      = 2'd3
    } tps_tgt_e;

    typedef enum logic [2:0] {
        POS_IDLE     = 3'd0,
        POS_PAUSE_IR = 3'd1,
        POS_PAUSE_DR = 3'd2,
        POS_SHIFT_IR = 3'd3,
        POS_SHIFT_DR = 3'd4
    } tps_pos_e;

    // Longest path is 7 bits; patterns are stored first-bit-in-LSB.
    localparam int PAT_W  = 8;
    localparam int LEN_W  = 4;
    localparam int PAT_IW = $clog2(PAT_W);

    typedef struct packed {
        logic             ok;
        logic [LEN_W-1:0] len;
        logic [PAT_W-1:0] pat;
        tps_pos_e         next;
    } tps_path_t;

endpackage

// File: rtl/tps_path_rom.sv
`timescale 1ns/1ps
module tps_path_rom
    import tps_pkg::*;
(
    input  logic [1:0] op,
    input  logic [2:0] start,
    input  logic [1:0] tgt,
    output tps_path_t  path
);

    logic from_idle;
    logic from_pause;
    logic from_shift;

    assign from_idle  = (start == POS_IDLE);
    assign from_pause = (start == POS_PAUSE_IR) || (start == POS_PAUSE_DR);
    assign from_shift = (start == POS_SHIFT_IR) || (start == POS_SHIFT_DR);

    always_comb begin
        path      = '0;
        path.next = POS_IDLE;
        unique case (op)
            OP_MOVE: begin
                unique case (tgt)
                    TGT_IDLE: begin
                        path.next = POS_IDLE;
                        if (from_idle) begin
                            path.ok = 1'b1; path.len = 4'd1; path.pat = 8'b0000_0000;
                        end else if (from_pause) begin
                            path.ok = 1'b1; path.len = 4'd3; path.pat = 8'b0000_0011;
                        end
                    end
                    TGT_PAUSE_IR: begin
                        path.next = POS_PAUSE_IR;
                        if (from_idle) begin
                            path.ok = 1'b1; path.len = 4'd5; path.pat = 8'b0000_1011;
                        end else if (from_pause) begin
                            path.ok = 1'b1; path.len = 4'd7; path.pat = 8'b0010_1111;
                        end
                    end
                    TGT_PAUSE_DR: begin
                        path.next = POS_PAUSE_DR;
                        if (from_idle) begin
                            path.ok = 1'b1; path.len = 4'd4; path.pat = 8'b0000_0101;
                        end else if (from_pause) begin
                            path.ok = 1'b1; path.len = 4'd6; path.pat = 8'b0001_0111;
                        end
                    end
                    default: path.ok = 1'b0;
                endcase
            end
            OP_SHIFT_IR: begin
                path.next = POS_SHIFT_IR;
                if (from_idle) begin
                    path.ok = 1'b1; path.len = 4'd4; path.pat = 8'b0000_0011;
                end else if (from_pause) begin
                    path.ok = 1'b1; path.len = 4'd6; path.pat = 8'b0000_1111;
                end
            end
            OP_SHIFT_DR: begin
                path.next = POS_SHIFT_DR;
                if (from_idle) begin
                    path.ok = 1'b1; path.len = 4'd3; path.pat = 8'b0000_0001;
                end else if (from_pause) begin
                    path.ok = 1'b1; path.len = 4'd5; path.pat = 8'b0000_0111;
                end
            end
            OP_EXIT: begin
                if (from_shift) begin
                    unique case (tgt)
                        TGT_IDLE: begin
                            path.ok = 1'b1; path.len = 4'd4; path.pat = 8'b0000_0110;
                            path.next = POS_IDLE;
                        end
                        TGT_PAUSE_IR, TGT_PAUSE_DR: begin
                            path.ok = 1'b1; path.len = 4'd1; path.pat = 8'b0000_0000;
                            path.next = (start == POS_SHIFT_IR) ? POS_PAUSE_IR : POS_PAUSE_DR;
                        end
                        default: path.ok = 1'b0;
                    endcase
                end
            end
            default: path.ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/tps_tck_gen.sv
`timescale 1ns/1ps
module tps_tck_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_go,
    input  logic bit_tms,
    output logic tck,
    output logic tms,
    output logic bit_free,
    output logic bit_end
);

    typedef enum logic [1:0] {PH_FREE, PH_LOW, PH_HIGH} ph_e;

    ph_e  ph_q, ph_d;
    logic tck_q, tms_q;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_FREE: if (bit_go) ph_d = PH_LOW;   // GO
            PH_LOW:  if (tick)   ph_d = PH_HIGH;  // RISE
            PH_HIGH: if (tick)   ph_d = PH_FREE;  // FALL
            default: ph_d = PH_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_FREE;
        else        ph_q <= ph_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tck_q <= 1'b0;
            tms_q <= 1'b0;
        end else begin
            if (ph_q == PH_FREE && bit_go) tms_q <= bit_tms;
            if (ph_q == PH_LOW  && tick)   tck_q <= 1'b1;
            if (ph_q == PH_HIGH && tick)   tck_q <= 1'b0;
        end
    end

    assign tck      = tck_q;
    assign tms      = tms_q;
    assign bit_free = (ph_q == PH_FREE);
    assign bit_end  = (ph_q == PH_HIGH) && tick;

endmodule

// File: rtl/tps_ctrl.sv
`timescale 1ns/1ps
module tps_ctrl
    import tps_pkg::*;
#(
    parameter int RESET_CLKS = 10,
    parameter int IDLE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_target,
    input  logic              req_reset,
    input  logic [IDLE_W-1:0] req_idle_clks,
    input  tps_path_t         path,
    output logic [1:0]        rom_op,
    output logic [2:0]        rom_start,
    output logic [1:0]        rom_tgt,
    input  logic              bit_free,
    input  logic              bit_end,
    output logic              bit_go,
    output logic              bit_tms,
    output logic              done,
    output logic              err,
    output logic [2:0]        tap_pos
);

    localparam int RST_W = $clog2(RESET_CLKS + 1);
    localparam int CW0   = (IDLE_W > RST_W) ? IDLE_W : RST_W;
    localparam int CNT_W = (CW0 > LEN_W) ? CW0 : LEN_W;

    typedef enum logic [2:0] {S_IDLE, S_BURST, S_PATH, S_EXTRA, S_DONE} st_e;

    st_e               st_q, st_d;
    logic [1:0]        op_q, tgt_q;
    tps_pos_e          start_q, pos_q, eff_start;
    logic [IDLE_W-1:0] idle_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;
    logic              use_burst;
    logic              seg_last;

    assign use_burst = req_reset && (req_op != OP_EXIT);
    assign eff_start = use_burst ? POS_IDLE : pos_q;

    // ROM sees the live request while waiting, the latched one afterwards
    assign rom_op    = (st_q == S_IDLE) ? req_op     : op_q;
    assign rom_start = (st_q == S_IDLE) ? eff_start  : start_q;
    assign rom_tgt   = (st_q == S_IDLE) ? req_target : tgt_q;

    always_comb begin
        seg_last = 1'b0;
        unique case (st_q)
            S_BURST: seg_last = (cnt_q + 1'b1) == CNT_W'(RESET_CLKS);
            S_PATH:  seg_last = (cnt_q + 1'b1) == CNT_W'(path.len);
            S_EXTRA: seg_last = (cnt_q + 1'b1) == CNT_W'(idle_q);
            default: seg_last = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (req_valid) begin                         // ACCEPT
                if (!path.ok)       st_d = S_DONE;
                else if (use_burst) st_d = S_BURST;
                else                st_d = S_PATH;
            end
            S_BURST: if (bit_end && seg_last) st_d = S_PATH;     // BURST_END
            S_PATH:  if (bit_end && seg_last)                    // PATH_END
                st_d = (op_q == OP_MOVE && idle_q != '0) ? S_EXTRA : S_DONE;
            S_EXTRA: if (bit_end && seg_last) st_d = S_DONE;     // EXTRA_END
            S_DONE:  st_d = S_IDLE;                              // COMMIT
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            tgt_q   <= '0;
            start_q <= POS_IDLE;
            idle_q  <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            pos_q   <= POS_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE: if (req_valid) begin
                    op_q    <= req_op;
                    tgt_q   <= req_target;
                    start_q <= eff_start;
                    idle_q  <= req_idle_clks;
                    cnt_q   <= '0;
                    err_q   <= !path.ok;
                end
                S_BURST, S_PATH, S_EXTRA: if (bit_end) begin
                    cnt_q <= seg_last ? '0 : cnt_q + 1'b1;
                end
                S_DONE: if (!err_q) pos_q <= path.next;
                default: ;
            endcase
        end
    end

    always_comb begin
        bit_tms = 1'b0;
        unique case (st_q)
            S_BURST: bit_tms = 1'b1;
            S_PATH:  bit_tms = path.pat[cnt_q[PAT_IW-1:0]];
            default: bit_tms = 1'b0;
        endcase
    end

    assign bit_go    = ((st_q == S_BURST) || (st_q == S_PATH) || (st_q == S_EXTRA)) && bit_free;
    assign req_ready = (st_q == S_IDLE);
    assign done      = (st_q == S_DONE);
    assign err       = (st_q == S_DONE) && err_q;
    assign tap_pos   = pos_q;

endmodule

// File: rtl/tap_path_seq.sv
`timescale 1ns/1ps
module tap_path_seq
    import tps_pkg::*;
#(
    parameter int RESET_CLKS = 10,
    parameter int IDLE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_target,
    input  logic              req_reset,
    input  logic [IDLE_W-1:0] req_idle_clks,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              done,
    output logic              err,
    output logic [2:0]        tap_pos
);

    tps_path_t  path;
    logic [1:0] rom_op, rom_tgt;
    logic [2:0] rom_start;
    logic       bit_free, bit_end, bit_go, bit_tms;

    tps_path_rom u_rom (
        .op    (rom_op),
        .start (rom_start),
        .tgt   (rom_tgt),
        .path  (path)
    );

    tps_ctrl #(
        .RESET_CLKS (RESET_CLKS),
        .IDLE_W     (IDLE_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_target    (req_target),
        .req_reset     (req_reset),
        .req_idle_clks (req_idle_clks),
        .path          (path),
        .rom_op        (rom_op),
        .rom_start     (rom_start),
        .rom_tgt       (rom_tgt),
        .bit_free      (bit_free),
        .bit_end       (bit_end),
        .bit_go        (bit_go),
        .bit_tms       (bit_tms),
        .done          (done),
        .err           (err),
        .tap_pos       (tap_pos)
    );

    tps_tck_gen u_tck (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bit_go   (bit_go),
        .bit_tms  (bit_tms),
        .tck      (tck),
        .tms      (tms),
        .bit_free (bit_free),
        .bit_end  (bit_end)
    );

    assign tdi = 1'b0;

endmodule

// File: rtl/tps_chk.sv
`timescale 1ns/1ps
module tps_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       req_ready,
    input logic       tck,
    input logic       tms,
    input logic       done,
    input logic       err,
    input logic [2:0] tap_pos
);

    // R9
    tms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck |=> (!tck || $stable(tms)));

    // R9
    tck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> $past(tick));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> !req_ready);

    // R8
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10
    pos_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap_pos) |-> $past(done));

    // R1
    pos_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_pos <= 3'd4);

endmodule

bind tap_path_seq tps_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .req_ready (req_ready),
    .tck       (tck),
    .tms       (tms),
    .done      (done),
    .err       (err),
    .tap_pos   (tap_pos)
);

// File: tb/sim_tap_path_seq.sv
`timescale 1ns/1ps
module sim_tap_path_seq;

    localparam int IDLE_W = 8;
    localparam int NV     = 25;

    typedef struct packed {
        logic [3:0]  tag;
        logic [1:0]  op;
        logic [1:0]  tgt;
        logic        rst;
        logic [7:0]  n;
        logic [5:0]  len;
        logic [31:0] bits;
        logic        err;
        logic [2:0]  pos;
    } vec_t;

    // tag, op, tgt, rst, n, len, bits (first bit LSB), err, pos
    localparam vec_t VEC [NV] = '{
        '{4'd2, 2'd0, 2'd0, 1'b0, 8'd0, 6'd1,  32'h0,    1'b0, 3'd0},
        '{4'd2, 2'd0, 2'd1, 1'b0, 8'd0, 6'd5,  32'h0B,   1'b0, 3'd1},
        '{4'd5, 2'd0, 2'd2, 1'b0, 8'd2, 6'd8,  32'h17,   1'b0, 3'd2},
        '{4'd3, 2'd0, 2'd1, 1'b0, 8'd0, 6'd7,  32'h2F,   1'b0, 3'd1},
        '{4'd5, 2'd0, 2'd0, 1'b0, 8'd3, 6'd6,  32'h03,   1'b0, 3'd0},
        '{4'd2, 2'd0, 2'd2, 1'b0, 8'd0, 6'd4,  32'h05,   1'b0, 3'd2},
        '{4'd6, 2'd2, 2'd0, 1'b0, 8'd5, 6'd5,  32'h07,   1'b0, 3'd4},
        '{4'd8, 2'd0, 2'd0, 1'b0, 8'd0, 6'd0,  32'h0,    1'b1, 3'd4},
        '{4'd7, 2'd3, 2'd1, 1'b0, 8'd0, 6'd1,  32'h0,    1'b0, 3'd2},
        '{4'd4, 2'd1, 2'd0, 1'b1, 8'd0, 6'd14, 32'h0FFF, 1'b0, 3'd3},
        '{4'd7, 2'd3, 2'd0, 1'b0, 8'd0, 6'd4,  32'h06,   1'b0, 3'd0},
        '{4'd8, 2'd3, 2'd0, 1'b0, 8'd0, 6'd0,  32'h0,    1'b1, 3'd0},
        '{4'd6, 2'd1, 2'd0, 1'b0, 8'd0, 6'd4,  32'h03,   1'b0, 3'd3},
        '{4'd7, 2'd3, 2'd2, 1'b0, 8'd0, 6'd1,  32'h0,    1'b0, 3'd1},
        '{4'd8, 2'd0, 2'd3, 1'b0, 8'd0, 6'd0,  32'h0,    1'b1, 3'd1},
        '{4'd4, 2'd0, 2'd0, 1'b1, 8'd1, 6'd12, 32'h3FF,  1'b0, 3'd0},
        '{4'd4, 2'd3, 2'd0, 1'b1, 8'd0, 6'd0,  32'h0,    1'b1, 3'd0},
        '{4'd8, 2'd0, 2'd3, 1'b1, 8'd0, 6'd0,  32'h0,    1'b1, 3'd0},
        '{4'd6, 2'd2, 2'd0, 1'b0, 8'd0, 6'd3,  32'h01,   1'b0, 3'd4},
        '{4'd7, 2'd3, 2'd0, 1'b0, 8'd0, 6'd4,  32'h06,   1'b0, 3'd0},
        '{4'd2, 2'd0, 2'd1, 1'b0, 8'd0, 6'd5,  32'h0B,   1'b0, 3'd1},
        '{4'd6, 2'd1, 2'd0, 1'b0, 8'd0, 6'd6,  32'h0F,   1'b0, 3'd3},
        '{4'd7, 2'd3, 2'd0, 1'b0, 8'd0, 6'd4,  32'h06,   1'b0, 3'd0},
        '{4'd2, 2'd0, 2'd2, 1'b0, 8'd0, 6'd4,  32'h05,   1'b0, 3'd2},
        '{4'd3, 2'd0, 2'd0, 1'b0, 8'd0, 6'd3,  32'h03,   1'b0, 3'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [1:0]        req_target = '0;
    logic              req_reset = 1'b0;
    logic [IDLE_W-1:0] req_idle_clks = '0;
    logic              tck, tms, tdi, done, err;
    logic [2:0]        tap_pos;

    int   checks = 0;
    int   errs = 0;
    int   cap_n = 0;
    int   tdi_bad = 0;
    logic cap_bits [512];
    logic got_err;
    bit   finished = 1'b0;

    tap_path_seq #(.RESET_CLKS(10), .IDLE_W(IDLE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_target(req_target),
        .req_reset(req_reset), .req_idle_clks(req_idle_clks),
        .tck(tck), .tms(tms), .tdi(tdi),
        .done(done), .err(err), .tap_pos(tap_pos)
    );

    always #2.5 clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick = (ph == 2);
            ph = (ph == 2) ? 0 : ph + 1;
        end
    end

    always @(posedge tck) begin
        if (cap_n < 512) cap_bits[cap_n] = tms;
        cap_n = cap_n + 1;
        if (tdi !== 1'b0) tdi_bad = tdi_bad + 1;
    end

    function automatic string tagname(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [1:0] tgt,
                           input logic rst, input logic [7:0] n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cap_n         = 0;
        req_valid     = 1'b1;
        req_op        = op;
        req_target    = tgt;
        req_reset     = rst;
        req_idle_clks = n;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got_err = err;
        @(negedge clk);
        chk("R10", "done width", {31'd0, done}, 32'd0);
    endtask

    function automatic logic [31:0] cap_word(input int len);
        logic [31:0] w = '0;
        for (int i = 0; i < len && i < 32; i++) w[i] = cap_bits[i];
        return w;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset values
        chk("R1", "tck", {31'd0, tck}, 32'd0);
        chk("R1", "tms", {31'd0, tms}, 32'd0);
        chk("R1", "done/err", {30'd0, done, err}, 32'd0);
        chk("R1", "ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "pos", {29'd0, tap_pos}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            string t;
            t = tagname(VEC[v].tag);
            run_req(VEC[v].op, VEC[v].tgt, VEC[v].rst, VEC[v].n);
            chk(t, "err", {31'd0, got_err}, {31'd0, VEC[v].err});
            chk(t, "clock count", cap_n, {26'd0, VEC[v].len});
            chk(t, "tms train", cap_word(int'(VEC[v].len)), VEC[v].bits);
            chk(t, "tap_pos", {29'd0, tap_pos}, {29'd0, VEC[v].pos});
        end

        // R5 full-range extra idle count from Idle
        run_req(2'd0, 2'd0, 1'b0, 8'd255);
        chk("R5", "long idle count", cap_n, 32'd256);
        begin
            int ones = 0;
            for (int i = 0; i < 256; i++) if (cap_bits[i] !== 1'b0) ones++;
            chk("R5", "long idle tms", ones, 32'd0);
        end

        // R10 ready low and valid held off while busy
        @(negedge clk);
        cap_n = 0;
        req_valid = 1'b1; req_op = 2'd0; req_target = 2'd1; req_reset = 1'b0; req_idle_clks = '0;
        @(negedge clk);
        req_valid = 1'b1; req_target = 2'd2;
        repeat (5) @(negedge clk);
        chk("R10", "ready while busy", {31'd0, req_ready}, 32'd0);
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "first train only", cap_n, 32'd5);
        @(negedge clk);
        chk("R10", "pos after done", {29'd0, tap_pos}, 32'd1);

        // R1 reset in the middle of a burst
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_target = 2'd0; req_reset = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "tck in reset", {31'd0, tck}, 32'd0);
        chk("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "pos in reset", {29'd0, tap_pos}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 TDI low at every rising TCK edge
        chk("R9", "tdi at rise", tdi_bad, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule